// File: doc/BRIEF.md
# Dispatch Group Former

This block sits between an in-order decoded-instruction queue and the dispatch stage of a superscalar core. It takes one decoded instruction per cycle over a valid/ready handshake. Each instruction carries a tag and a class code. The block packs instructions into dispatch groups of six slots. Four slots hold non-branch work and two slots hold branches. A finished group is presented on a registered output with a per-slot valid bit, tag and class.

Groups follow slot-placement rules. A branch does not close its group, but a second branch does. Some classes must sit at the head of a group. Others take two or all four non-branch slots, and a multi-slot instruction is never split across two groups. When an arriving instruction cannot be placed legally, the group under construction is emitted in the same cycle and the new instruction starts the next group. A group is also emitted as soon as the input runs dry. While the consumer is not ready, the output group is frozen and no input is accepted.

Top module: `dispatch_group_former`

## Requirements
- R1: During and right after reset, `grp_valid` is 0, `slot_valid` is all zero and `in_ready` is 1. Whenever `grp_valid` is 0, `slot_valid` is all zero.
- R2: Class codes are 0 ordinary, 1 branch, 2 head-only, 3 pair, 4 quad and 5 permute. Slot k occupies bit k of `slot_valid`, bits [k*TAG_W +: TAG_W] of `slot_tag` and bits [k*3 +: 3] of `slot_cls`. Non-branch instructions fill slots 0 to 3 in program order, and branches fill slots 4 then 5.
- R3: A first branch leaves the group open, so later ordinary instructions still join it in slots 0 to 3.
- R4: A second branch is the last member of its group. The group is emitted at the edge that accepts that branch, and the next instruction opens a new group.
- R5: A head-only instruction (class 2) is placed only in slot 0 of an otherwise empty group, so it always starts a group. Ordinary instructions may follow it into slot 1 onward.
- R6: A pair instruction (class 3) starts a group and occupies slots 0 and 1, both reporting its tag and class.
- R7: A quad instruction (class 4) starts a group and occupies slots 0 to 3. Only branches may join it afterwards.
- R8: A permute instruction (class 5) goes to slot 0 or slot 1. If two or more non-branch slots are already used, it starts a new group.
- R9: When an instruction does not fit the group being built, that group is emitted and the instruction is accepted in the same cycle as the first member of the next group, so a steady input stream is never stalled.
- R10: In a cycle with no valid input, a partially built group is emitted rather than held.
- R11: While `grp_valid` is 1 and `grp_ready` is 0, the group outputs stay unchanged and `in_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Head instruction present |
| in_ready | output | 1 | Head instruction accepted at this edge |
| in_tag | input | TAG_W | Tag of the head instruction |
| in_cls | input | 3 | Class code of the head instruction |
| grp_valid | output | 1 | A dispatch group is presented |
| grp_ready | input | 1 | Consumer takes the group at this edge |
| slot_valid | output | 6 | Per-slot occupancy |
| slot_tag | output | 6*TAG_W | Per-slot tag |
| slot_cls | output | 18 | Per-slot class code |

## Verification
Two functions can act in the same cycle: emitting the finished group and accepting the instruction that did not fit, which becomes the head of the next group. The bench provokes this by streaming five ordinary instructions back to back, and also with head-only, pair, quad and permute instructions arriving behind a partly filled group. It judges the result from the sequence of captured groups and from the number of cycles the stream took. A second overlap is a back-pressured output together with a waiting input. A stalled consumer is held against a valid head instruction, and the bench checks that the outputs stay frozen and nothing is taken.

// File: rtl/dgf_pkg.sv
`timescale 1ns/1ps
package dgf_pkg;
  localparam int CLS_W = 3;

  typedef enum logic [CLS_W-1:0] {
    CL_ALU  = 3'd0,
    CL_BR   = 3'd1,
    CL_SOLO = 3'd2,
    CL_PAIR = 3'd3,
    CL_QUAD = 3'd4,
    CL_PERM = 3'd5
  } cls_e;
endpackage

// File: rtl/dgf_insert.sv
`timescale 1ns/1ps
// Places one instruction into a partially built group, if the slot rules allow it.
module dgf_insert
  import dgf_pkg::*;
#(
  parameter int TAG_W    = 8,
  parameter int NB_SLOTS = 4,
  parameter int BR_SLOTS = 2,
  localparam int SLOTS   = NB_SLOTS + BR_SLOTS,
  localparam int NBC_W   = $clog2(NB_SLOTS + 1),
  localparam int BRC_W   = $clog2(BR_SLOTS + 1)
) (
  input  logic [SLOTS-1:0]       base_v,
  input  logic [SLOTS*TAG_W-1:0] base_t,
  input  logic [SLOTS*CLS_W-1:0] base_c,
  input  logic [NBC_W-1:0]       base_nb,
  input  logic [BRC_W-1:0]       base_br,
  input  logic [CLS_W-1:0]       in_cls,
  input  logic [TAG_W-1:0]       in_tag,
  output logic                   fits,
  output logic [SLOTS-1:0]       new_v,
  output logic [SLOTS*TAG_W-1:0] new_t,
  output logic [SLOTS*CLS_W-1:0] new_c,
  output logic [NBC_W-1:0]       new_nb,
  output logic [BRC_W-1:0]       new_br
);
  logic empty, open_br, is_br;
  int   span;

  assign empty   = (base_nb == '0) && (base_br == '0);
  assign open_br = int'(base_br) < BR_SLOTS;

  always_comb begin
    is_br = 1'b0;
    span  = 1;
    case (cls_e'(in_cls))
      CL_BR: begin
        is_br = 1'b1;
        span  = 0;
        fits  = open_br;
      end
      CL_SOLO: fits = empty;
      CL_PAIR: begin
        span = 2;
        fits = empty;
      end
      CL_QUAD: begin
        span = NB_SLOTS;
        fits = empty;
      end
      CL_PERM: fits = open_br && (int'(base_nb) < 2);
      default: fits = open_br && (int'(base_nb) < NB_SLOTS);
    endcase
  end

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    logic hit;
    if (i < NB_SLOTS) begin : g_nb
      assign hit = fits && !is_br && (i >= int'(base_nb)) && (i < int'(base_nb) + span);
    end else begin : g_br
      assign hit = fits && is_br && ((i - NB_SLOTS) == int'(base_br));
    end
    assign new_v[i]                  = base_v[i] | hit;
    assign new_t[i*TAG_W +: TAG_W]   = hit ? in_tag : base_t[i*TAG_W +: TAG_W];
    assign new_c[i*CLS_W +: CLS_W]   = hit ? in_cls : base_c[i*CLS_W +: CLS_W];
  end

  assign new_nb = (fits && !is_br) ? base_nb + NBC_W'(span) : base_nb;
  assign new_br = (fits && is_br)  ? base_br + BRC_W'(1)    : base_br;
endmodule

// File: rtl/dgf_group_reg.sv
`timescale 1ns/1ps
// Registered group output; loads only when the consumer side is free.
module dgf_group_reg #(
  parameter int W_V = 6,
  parameter int W_T = 48,
  parameter int W_C = 18
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ld,
  input  logic           nxt_valid,
  input  logic [W_V-1:0] nxt_v,
  input  logic [W_T-1:0] nxt_t,
  input  logic [W_C-1:0] nxt_c,
  output logic           grp_valid,
  output logic [W_V-1:0] slot_v,
  output logic [W_T-1:0] slot_t,
  output logic [W_C-1:0] slot_c
);
  always_ff @(posedge clk) begin
    if (rst) begin
      grp_valid <= 1'b0;
      slot_v    <= '0;
      slot_t    <= '0;
      slot_c    <= '0;
    end else if (ld) begin
      grp_valid <= nxt_valid;
      slot_v    <= nxt_valid ? nxt_v : '0;
      slot_t    <= nxt_valid ? nxt_t : '0;
      slot_c    <= nxt_valid ? nxt_c : '0;
    end
  end
endmodule

// File: rtl/dispatch_group_former.sv
`timescale 1ns/1ps
module dispatch_group_former
  import dgf_pkg::*;
#(
  parameter int TAG_W    = 8,
  parameter int NB_SLOTS = 4,
  parameter int BR_SLOTS = 2
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 in_valid,
  output logic                                 in_ready,
  input  logic [TAG_W-1:0]                     in_tag,
  input  logic [2:0]                           in_cls,
  output logic                                 grp_valid,
  input  logic                                 grp_ready,
  output logic [NB_SLOTS+BR_SLOTS-1:0]         slot_valid,
  output logic [(NB_SLOTS+BR_SLOTS)*TAG_W-1:0] slot_tag,
  output logic [(NB_SLOTS+BR_SLOTS)*3-1:0]     slot_cls
);
  localparam int SLOTS = NB_SLOTS + BR_SLOTS;
  localparam int NBC_W = $clog2(NB_SLOTS + 1);
  localparam int BRC_W = $clog2(BR_SLOTS + 1);
  localparam int TW    = SLOTS * TAG_W;
  localparam int CW    = SLOTS * CLS_W;

  // group under construction
  logic [SLOTS-1:0] bld_v;
  logic [TW-1:0]    bld_t;
  logic [CW-1:0]    bld_c;
  logic [NBC_W-1:0] bld_nb;
  logic [BRC_W-1:0] bld_br;

  // builder with the head merged in, and the head alone in a fresh group
  logic             m_fits, s_fits, m_closes;
  logic [SLOTS-1:0] m_v, s_v;
  logic [TW-1:0]    m_t, s_t;
  logic [CW-1:0]    m_c, s_c;
  logic [NBC_W-1:0] m_nb, s_nb;
  logic [BRC_W-1:0] m_br, s_br;

  logic             out_free, emit;
  logic [SLOTS-1:0] e_v, n_v;
  logic [TW-1:0]    e_t, n_t;
  logic [CW-1:0]    e_c, n_c;
  logic [NBC_W-1:0] n_nb;
  logic [BRC_W-1:0] n_br;

  dgf_insert #(.TAG_W(TAG_W), .NB_SLOTS(NB_SLOTS), .BR_SLOTS(BR_SLOTS)) u_merge (
    .base_v(bld_v), .base_t(bld_t), .base_c(bld_c), .base_nb(bld_nb), .base_br(bld_br),
    .in_cls(in_cls), .in_tag(in_tag), .fits(m_fits),
    .new_v(m_v), .new_t(m_t), .new_c(m_c), .new_nb(m_nb), .new_br(m_br)
  );

  dgf_insert #(.TAG_W(TAG_W), .NB_SLOTS(NB_SLOTS), .BR_SLOTS(BR_SLOTS)) u_fresh (
    .base_v('0), .base_t('0), .base_c('0), .base_nb('0), .base_br('0),
    .in_cls(in_cls), .in_tag(in_tag), .fits(s_fits),
    .new_v(s_v), .new_t(s_t), .new_c(s_c), .new_nb(s_nb), .new_br(s_br)
  );

  assign out_free = !grp_valid || grp_ready;
  assign in_ready = out_free;
  assign m_closes = m_fits && (in_cls == CL_BR) && (int'(bld_br) == BR_SLOTS - 1);

  always_comb begin
    emit = 1'b0;
    e_v  = bld_v;  e_t  = bld_t;  e_c  = bld_c;
    n_v  = bld_v;  n_t  = bld_t;  n_c  = bld_c;
    n_nb = bld_nb; n_br = bld_br;
    if (in_valid && m_fits) begin
      if (m_closes) begin
        emit = 1'b1;
        e_v  = m_v; e_t = m_t; e_c = m_c;
        n_v  = '0;  n_t = '0;  n_c = '0;
        n_nb = '0;  n_br = '0;
      end else begin
        n_v  = m_v;  n_t  = m_t;  n_c = m_c;
        n_nb = m_nb; n_br = m_br;
      end
    end else if (in_valid && s_fits) begin
      emit = 1'b1;
      n_v  = s_v;  n_t  = s_t;  n_c = s_c;
      n_nb = s_nb; n_br = s_br;
    end else if ((bld_nb != '0) || (bld_br != '0)) begin
      emit = 1'b1;
      n_v  = '0; n_t = '0; n_c = '0;
      n_nb = '0; n_br = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bld_v  <= '0;
      bld_t  <= '0;
      bld_c  <= '0;
      bld_nb <= '0;
      bld_br <= '0;
    end else if (out_free) begin
      bld_v  <= n_v;
      bld_t  <= n_t;
      bld_c  <= n_c;
      bld_nb <= n_nb;
      bld_br <= n_br;
    end
  end

  dgf_group_reg #(.W_V(SLOTS), .W_T(TW), .W_C(CW)) u_out (
    .clk(clk), .rst(rst), .ld(out_free), .nxt_valid(emit),
    .nxt_v(e_v), .nxt_t(e_t), .nxt_c(e_c),
    .grp_valid(grp_valid), .slot_v(slot_valid), .slot_t(slot_tag), .slot_c(slot_cls)
  );

  // ---------------- assertions ----------------
  assert_idle_clear_R1: assert property (@(posedge clk) disable iff (rst)
    !grp_valid |-> (slot_valid == '0));

  assert_group_nonempty_R2: assert property (@(posedge clk) disable iff (rst)
    grp_valid |-> (slot_valid != '0));

  for (genvar k = 1; k < NB_SLOTS; k++) begin : g_nb_chk
    assert_nb_packed_R2: assert property (@(posedge clk) disable iff (rst)
      (grp_valid && slot_valid[k]) |-> slot_valid[k-1]);
  end

  for (genvar k = 2; k < NB_SLOTS; k++) begin : g_perm_chk
    assert_perm_low_R8: assert property (@(posedge clk) disable iff (rst)
      (grp_valid && slot_valid[k]) |-> (slot_cls[k*CLS_W +: CLS_W] != CL_PERM));
  end

  for (genvar k = NB_SLOTS; k < SLOTS; k++) begin : g_br_chk
    assert_branch_slot_R2: assert property (@(posedge clk) disable iff (rst)
      (grp_valid && slot_valid[k]) |-> (slot_cls[k*CLS_W +: CLS_W] == CL_BR));
  end

  assert_second_branch_last_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && (in_cls == CL_BR) && (int'(bld_br) == BR_SLOTS - 1))
    |=> (grp_valid && slot_valid[SLOTS-1] &&
         (slot_tag[(SLOTS-1)*TAG_W +: TAG_W] == $past(in_tag)) && (bld_br == '0)));

  assert_fresh_fit_R9: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> s_fits);

  assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (grp_valid && !grp_ready) |=> (grp_valid && $stable(slot_valid) &&
                                   $stable(slot_tag) && $stable(slot_cls)));

  assert_no_take_R11: assert property (@(posedge clk) disable iff (rst)
    (grp_valid && !grp_ready) |-> !in_ready);
endmodule

// File: tb/sim_dispatch_group_former.sv
`timescale 1ns/1ps
module sim_dispatch_group_former;
  localparam int TW = 8;
  localparam int NS = 6;
  localparam int ALU = 0, BRN = 1, SOLO = 2, PAIR = 3, QUAD = 4, PERM = 5;

  logic              clk = 1'b0;
  logic              rst;
  logic              in_valid, in_ready;
  logic [TW-1:0]     in_tag;
  logic [2:0]        in_cls;
  logic              grp_valid, grp_ready;
  logic [NS-1:0]     slot_valid;
  logic [NS*TW-1:0]  slot_tag;
  logic [NS*3-1:0]   slot_cls;

  int checks = 0, failures = 0, cyc = 0;

  always #10 clk = ~clk; // 50 MHz

  dispatch_group_former #(.TAG_W(TW), .NB_SLOTS(4), .BR_SLOTS(2)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_tag(in_tag), .in_cls(in_cls), .grp_valid(grp_valid), .grp_ready(grp_ready),
    .slot_valid(slot_valid), .slot_tag(slot_tag), .slot_cls(slot_cls)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // captured groups, taken at negedge when a transfer will happen at the next edge
  logic [NS+NS*TW+NS*3-1:0] cap_q[$];
  logic [NS+NS*TW+NS*3-1:0] exp_q[$];
  logic [NS-1:0]    e_v;
  logic [NS*TW-1:0] e_t;
  logic [NS*3-1:0]  e_c;

  always @(negedge clk)
    if (!rst && grp_valid && grp_ready) cap_q.push_back({slot_valid, slot_tag, slot_cls});

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  task automatic ex_slot(input int s, input int tag, input int cls);
    e_v[s] = 1'b1;
    e_t[s*TW +: TW] = TW'(tag);
    e_c[s*3 +: 3] = 3'(cls);
  endtask

  task automatic ex_push();
    exp_q.push_back({e_v, e_t, e_c});
    e_v = '0; e_t = '0; e_c = '0;
  endtask

  task automatic compare(input string req);
    chk(cap_q.size() == exp_q.size(), req, "group count", 128'(cap_q.size()), 128'(exp_q.size()));
    for (int i = 0; i < exp_q.size(); i++) begin
      if (i < cap_q.size())
        chk(cap_q[i] == exp_q[i], req, $sformatf("group %0d", i), 128'(cap_q[i]), 128'(exp_q[i]));
      else
        chk(1'b0, req, $sformatf("group %0d missing", i), 128'(0), 128'(exp_q[i]));
    end
    cap_q.delete();
    exp_q.delete();
  endtask

  // called just after a posedge; returns just after the edge that accepted it
  task automatic push(input int cls, input int tag);
    bit acc;
    in_valid = 1'b1;
    in_cls   = 3'(cls);
    in_tag   = TW'(tag);
    forever begin
      @(negedge clk);
      acc = in_ready;
      @(posedge clk);
      #1;
      if (acc) break;
    end
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic t_reset();
    rst = 1'b1; in_valid = 1'b0; in_tag = '0; in_cls = '0; grp_ready = 1'b1;
    e_v = '0; e_t = '0; e_c = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(grp_valid == 1'b0, "R1", "grp_valid in reset", 128'(grp_valid), 128'(0));
    rst = 1'b0;
    @(posedge clk); #1;
    @(negedge clk);
    chk(grp_valid == 1'b0, "R1", "grp_valid after reset", 128'(grp_valid), 128'(0));
    chk(slot_valid == '0, "R1", "slot_valid after reset", 128'(slot_valid), 128'(0));
    chk(in_ready == 1'b1, "R1", "in_ready after reset", 128'(in_ready), 128'(1));
    @(posedge clk); #1;
  endtask

  task automatic t_fill();  // R2 ordering, R10 flush on empty input
    push(ALU, 1); push(ALU, 2); push(ALU, 3);
    idle(4);
    ex_slot(0, 1, ALU); ex_slot(1, 2, ALU); ex_slot(2, 3, ALU); ex_push();
    compare("R10");
    push(BRN, 5); push(ALU, 6);
    idle(4);
    ex_slot(0, 6, ALU); ex_slot(4, 5, BRN); ex_push();
    compare("R2");
  endtask

  task automatic t_branch_mid();  // R3
    push(ALU, 1); push(BRN, 2); push(ALU, 3); push(ALU, 4);
    idle(4);
    ex_slot(0, 1, ALU); ex_slot(1, 3, ALU); ex_slot(2, 4, ALU); ex_slot(4, 2, BRN); ex_push();
    compare("R3");
  endtask

  task automatic t_two_br();  // R4
    push(ALU, 10); push(BRN, 11); push(BRN, 12);
    @(negedge clk);
    chk(grp_valid && slot_valid[5], "R4", "emitted at second branch",
        128'({grp_valid, slot_valid}), 128'({1'b1, 6'b110001}));
    @(posedge clk); #1;
    push(ALU, 13);
    idle(4);
    ex_slot(0, 10, ALU); ex_slot(4, 11, BRN); ex_slot(5, 12, BRN); ex_push();
    ex_slot(0, 13, ALU); ex_push();
    compare("R4");
  endtask

  task automatic t_overflow();  // R9
    int c0;
    c0 = cyc;
    for (int i = 0; i < 5; i++) push(ALU, 20 + i);
    chk(cyc - c0 == 5, "R9", "cycles for five instructions", 128'(cyc - c0), 128'(5));
    idle(4);
    ex_slot(0, 20, ALU); ex_slot(1, 21, ALU); ex_slot(2, 22, ALU); ex_slot(3, 23, ALU); ex_push();
    ex_slot(0, 24, ALU); ex_push();
    compare("R9");
  endtask

  task automatic t_solo();  // R5
    push(ALU, 30); push(SOLO, 31); push(ALU, 32);
    idle(4);
    ex_slot(0, 30, ALU); ex_push();
    ex_slot(0, 31, SOLO); ex_slot(1, 32, ALU); ex_push();
    compare("R5");
  endtask

  task automatic t_pair();  // R6
    push(ALU, 40); push(PAIR, 41); push(ALU, 42); push(ALU, 43); push(ALU, 44);
    idle(4);
    ex_slot(0, 40, ALU); ex_push();
    ex_slot(0, 41, PAIR); ex_slot(1, 41, PAIR); ex_slot(2, 42, ALU); ex_slot(3, 43, ALU); ex_push();
    ex_slot(0, 44, ALU); ex_push();
    compare("R6");
  endtask

  task automatic t_quad();  // R7
    push(QUAD, 50); push(BRN, 51); push(ALU, 52); push(BRN, 53); push(QUAD, 54);
    idle(4);
    for (int s = 0; s < 4; s++) ex_slot(s, 50, QUAD);
    ex_slot(4, 51, BRN); ex_push();
    ex_slot(0, 52, ALU); ex_slot(4, 53, BRN); ex_push();
    for (int s = 0; s < 4; s++) ex_slot(s, 54, QUAD);
    ex_push();
    compare("R7");
  endtask

  task automatic t_perm();  // R8
    push(PERM, 60); push(ALU, 61);
    idle(3);
    push(ALU, 62); push(PERM, 63);
    idle(3);
    push(ALU, 64); push(ALU, 65); push(PERM, 66);
    idle(4);
    ex_slot(0, 60, PERM); ex_slot(1, 61, ALU); ex_push();
    ex_slot(0, 62, ALU); ex_slot(1, 63, PERM); ex_push();
    ex_slot(0, 64, ALU); ex_slot(1, 65, ALU); ex_push();
    ex_slot(0, 66, PERM); ex_push();
    compare("R8");
  endtask

  task automatic t_stall();  // R11
    logic [NS+NS*TW+NS*3-1:0] snap;
    grp_ready = 1'b0;
    push(ALU, 70); push(ALU, 71);
    idle(3);
    @(negedge clk);
    snap = {slot_valid, slot_tag, slot_cls};
    chk(grp_valid == 1'b1, "R11", "group presented", 128'(grp_valid), 128'(1));
    @(posedge clk); #1;
    in_valid = 1'b1; in_cls = 3'(ALU); in_tag = 8'd72;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(in_ready == 1'b0, "R11", "input blocked", 128'(in_ready), 128'(0));
      chk({slot_valid, slot_tag, slot_cls} == snap && grp_valid, "R11", "outputs frozen",
          128'({slot_valid, slot_tag, slot_cls}), 128'(snap));
    end
    @(posedge clk); #1;
    grp_ready = 1'b1;
    push(ALU, 72);
    idle(4);
    ex_slot(0, 70, ALU); ex_slot(1, 71, ALU); ex_push();
    ex_slot(0, 72, ALU); ex_push();
    compare("R11");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_fill();
    t_branch_mid();
    t_two_br();
    t_overflow();
    t_solo();
    t_pair();
    t_quad();
    t_perm();
    t_stall();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule